// File: doc/BRIEF.md
# Four-Channel Sample Level Trigger

This block watches the digitized sample streams of four acquisition channels and raises a trigger when a programmed condition is seen. Each channel can detect one of four conditions: a crossing of its upper level upwards or downwards, or the sample moving into or out of the band bounded by its lower and upper levels. A channel can also be switched off. The comparison uses only the most significant bits of each sample, so the trigger threshold has a coarser resolution than the sample.

The levels are six-bit two's-complement numbers in the range -31 to +31. The code -32 is never stored, which keeps the range symmetric. The levels, the per-channel modes, a global enable and a combine select sit in a small register bank. Software reaches that bank over a simple address/data bus with a write strobe and a combinational read port. A read-only register reports how many distinct level codes can be used.

The per-channel results are registered together with one merged trigger output. The merged output is formed by OR or by AND across the channels, as the combine select picks. In AND mode, channels that are off count as true.

Top module: `lvl_trig_top`

## Requirements
- R1: After reset every level reads 0, every channel is off, `trig_o` and `ch_trig_o` are 0, and the first accepted sample after reset never produces an edge or window event.
- R2: Address 0x02 reads 2^LVL_W-1, which is 0x3F for six-bit levels. A write to that address changes nothing.
- R3: A level write whose low six data bits are 100000 (-32) stores -31. A level reads back sign-extended to eight bits, so -31 reads as 0xE1. No level register ever holds -32.
- R4: Only sample bits [11:6] are compared, as a signed value. The bits below them have no effect on the trigger.
- R5: Mode 1 (rise) fires when the previous top bits are below the channel's upper level and the current top bits are at or above it. The pulse on `ch_trig_o[c]` and `trig_o` appears in the cycle after the edge on which `samp_vld_i` was high, and lasts one cycle.
- R6: Mode 2 (fall) fires when the previous top bits are at or above the upper level and the current top bits are below it.
- R7: Mode 3 (enter) fires when the sample moves from outside to inside the band lower <= s <= upper, with both bounds inclusive.
- R8: Mode 4 (exit) fires when the sample moves from inside that inclusive band to outside it.
- R9: Mode 0 (off), and the unused codes 5 to 7, never drive `ch_trig_o[c]` high.
- R10: Address 0x01 bit 0 selects the combine. With 0, `trig_o` is the OR of the active channel results. With 1, it is the AND, where off channels count as true and at least one channel must be active.
- R11: Address 0x00 bit 0 is the global enable. While it is 0, `trig_o` and `ch_trig_o` stay 0.
- R12: Register map: mode of channel c at 0x10+c, upper level at 0x20+c, lower level at 0x28+c. Each register reads back what was written, apart from the clamp in R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data, combinational from the address |
| samp_vld_i | input | 1 | All channel samples valid this cycle |
| samp_i | input | 48 | Four 12-bit samples, channel c at bits [12c+11:12c] |
| trig_o | output | 1 | Merged trigger pulse |
| ch_trig_o | output | 4 | Per-channel trigger pulses |

## Verification
The assertions check on every cycle that no level register ever holds -32, and that no trigger follows a cycle without a valid sample. They also check that a channel that is off stays quiet, that the global enable gates every output, and that an OR-mode channel hit always reaches the merged output. Only the bench scenarios can show the conditions themselves. These are the edge directions, the inclusive window bounds, that the low sample bits are ignored, that the first sample after reset is suppressed, the AND rule for off channels, and the clamped readback of -32.

// File: rtl/lvl_trig_pkg.sv
package lvl_trig_pkg;
  typedef enum logic [2:0] {
    MODE_OFF     = 3'd0,
    MODE_RISE    = 3'd1,
    MODE_FALL    = 3'd2,
    MODE_WIN_IN  = 3'd3,
    MODE_WIN_OUT = 3'd4
  } trig_mode_e;

  localparam int          MODE_W  = 3;
  localparam int          ADDR_W  = 8;
  localparam logic [7:0]  A_GLB   = 8'h00;
  localparam logic [7:0]  A_COMB  = 8'h01;
  localparam logic [7:0]  A_CNT   = 8'h02;
  localparam logic [7:0]  A_MODE  = 8'h10;
  localparam logic [7:0]  A_UPPER = 8'h20;
  localparam logic [7:0]  A_LOWER = 8'h28;
endpackage

// File: rtl/lvl_reg_bank.sv
module lvl_reg_bank
  import lvl_trig_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int LVL_W  = 6,
  parameter int DATA_W = 8
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       we_i,
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic [DATA_W-1:0]          wdata_i,
  output logic [DATA_W-1:0]          rdata_o,
  output logic                       glb_en_o,
  output logic                       comb_and_o,
  output logic [NUM_CH*MODE_W-1:0]   mode_o,
  output logic [NUM_CH*LVL_W-1:0]    upper_o,
  output logic [NUM_CH*LVL_W-1:0]    lower_o
);
  localparam logic [LVL_W-1:0]  LVL_MIN   = {1'b1, {(LVL_W-1){1'b0}}};
  localparam logic [LVL_W-1:0]  LVL_CLAMP = LVL_MIN + 1'b1;
  localparam int                LVL_CNT   = (2**LVL_W) - 1;
  localparam int                EXT_W     = DATA_W - LVL_W;

  logic [LVL_W-1:0]  up_q [NUM_CH];
  logic [LVL_W-1:0]  lo_q [NUM_CH];
  logic [MODE_W-1:0] md_q [NUM_CH];
  logic              glb_q, comb_q;

  function automatic logic [LVL_W-1:0] clamp_lvl(input logic [LVL_W-1:0] v);
    return (v == LVL_MIN) ? LVL_CLAMP : v;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      glb_q  <= 1'b0;
      comb_q <= 1'b0;
    end else if (we_i) begin
      if (addr_i == A_GLB)  glb_q  <= wdata_i[0];
      if (addr_i == A_COMB) comb_q <= wdata_i[0];
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        up_q[c] <= '0;
        lo_q[c] <= '0;
        md_q[c] <= MODE_OFF;
      end else if (we_i) begin
        if (addr_i == A_UPPER + ADDR_W'(c)) up_q[c] <= clamp_lvl(wdata_i[LVL_W-1:0]);
        if (addr_i == A_LOWER + ADDR_W'(c)) lo_q[c] <= clamp_lvl(wdata_i[LVL_W-1:0]);
        if (addr_i == A_MODE  + ADDR_W'(c)) md_q[c] <= wdata_i[MODE_W-1:0];
      end
    end
    assign upper_o[c*LVL_W +: LVL_W]   = up_q[c];
    assign lower_o[c*LVL_W +: LVL_W]   = lo_q[c];
    assign mode_o[c*MODE_W +: MODE_W]  = md_q[c];
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == A_GLB)  rdata_o = DATA_W'(glb_q);
    if (addr_i == A_COMB) rdata_o = DATA_W'(comb_q);
    if (addr_i == A_CNT)  rdata_o = DATA_W'(LVL_CNT);
    for (int c = 0; c < NUM_CH; c++) begin
      if (addr_i == A_UPPER + ADDR_W'(c)) rdata_o = {{EXT_W{up_q[c][LVL_W-1]}}, up_q[c]};
      if (addr_i == A_LOWER + ADDR_W'(c)) rdata_o = {{EXT_W{lo_q[c][LVL_W-1]}}, lo_q[c]};
      if (addr_i == A_MODE  + ADDR_W'(c)) rdata_o = DATA_W'(md_q[c]);
    end
  end

  assign glb_en_o   = glb_q;
  assign comb_and_o = comb_q;
endmodule

// File: rtl/lvl_chan_cmp.sv
module lvl_chan_cmp
  import lvl_trig_pkg::*;
#(
  parameter int LVL_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              vld_i,
  input  logic [LVL_W-1:0]  top_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic [LVL_W-1:0]  upper_i,
  input  logic [LVL_W-1:0]  lower_i,
  output logic              hit_o,
  output logic              active_o
);
  logic signed [LVL_W-1:0] cur_s, prev_q, up_s, lo_s;
  logic                    prev_vld_q;
  logic                    in_cur, in_prev, cond;

  assign cur_s = top_i;
  assign up_s  = upper_i;
  assign lo_s  = lower_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q     <= '0;
      prev_vld_q <= 1'b0;
    end else if (vld_i) begin
      prev_q     <= cur_s;
      prev_vld_q <= 1'b1;
    end
  end

  assign in_cur  = (cur_s  >= lo_s) && (cur_s  <= up_s);
  assign in_prev = (prev_q >= lo_s) && (prev_q <= up_s);

  always_comb begin
    cond     = 1'b0;
    active_o = 1'b1;
    case (mode_i)
      MODE_RISE:    cond = (prev_q <  up_s) && (cur_s >= up_s);
      MODE_FALL:    cond = (prev_q >= up_s) && (cur_s <  up_s);
      MODE_WIN_IN:  cond = !in_prev &&  in_cur;
      MODE_WIN_OUT: cond =  in_prev && !in_cur;
      default:      active_o = 1'b0;
    endcase
  end

  assign hit_o = vld_i && prev_vld_q && cond;
endmodule

// File: rtl/lvl_trig_comb.sv
module lvl_trig_comb #(
  parameter int NUM_CH = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              glb_en_i,
  input  logic              comb_and_i,
  input  logic [NUM_CH-1:0] hit_i,
  input  logic [NUM_CH-1:0] active_i,
  output logic              trig_o,
  output logic [NUM_CH-1:0] ch_trig_o
);
  logic [NUM_CH-1:0] live;
  logic              any_hit, all_hit, merged;

  assign live    = hit_i & active_i;
  assign any_hit = |live;
  assign all_hit = (&(hit_i | ~active_i)) && (|active_i);
  assign merged  = comb_and_i ? all_hit : any_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trig_o    <= 1'b0;
      ch_trig_o <= '0;
    end else begin
      trig_o    <= glb_en_i && merged;
      ch_trig_o <= glb_en_i ? live : '0;
    end
  end
endmodule

// File: rtl/lvl_trig_top.sv
module lvl_trig_top
  import lvl_trig_pkg::*;
#(
  parameter int NUM_CH   = 4,
  parameter int SAMPLE_W = 12,
  parameter int LVL_W    = 6,
  parameter int DATA_W   = 8
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       reg_we_i,
  input  logic [ADDR_W-1:0]          reg_addr_i,
  input  logic [DATA_W-1:0]          reg_wdata_i,
  output logic [DATA_W-1:0]          reg_rdata_o,
  input  logic                       samp_vld_i,
  input  logic [NUM_CH*SAMPLE_W-1:0] samp_i,
  output logic                       trig_o,
  output logic [NUM_CH-1:0]          ch_trig_o
);
  logic                     glb_en, comb_and;
  logic [NUM_CH*MODE_W-1:0] mode_flat;
  logic [NUM_CH*LVL_W-1:0]  upper_flat, lower_flat;
  logic [NUM_CH-1:0]        hit, active;

  lvl_reg_bank #(.NUM_CH(NUM_CH), .LVL_W(LVL_W), .DATA_W(DATA_W)) u_bank (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (reg_we_i),
    .addr_i     (reg_addr_i),
    .wdata_i    (reg_wdata_i),
    .rdata_o    (reg_rdata_o),
    .glb_en_o   (glb_en),
    .comb_and_o (comb_and),
    .mode_o     (mode_flat),
    .upper_o    (upper_flat),
    .lower_o    (lower_flat)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_cmp
    lvl_chan_cmp #(.LVL_W(LVL_W)) u_cmp (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .vld_i    (samp_vld_i),
      .top_i    (samp_i[c*SAMPLE_W + SAMPLE_W - 1 -: LVL_W]),
      .mode_i   (mode_flat[c*MODE_W +: MODE_W]),
      .upper_i  (upper_flat[c*LVL_W +: LVL_W]),
      .lower_i  (lower_flat[c*LVL_W +: LVL_W]),
      .hit_o    (hit[c]),
      .active_o (active[c])
    );
  end

  lvl_trig_comb #(.NUM_CH(NUM_CH)) u_comb (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .glb_en_i   (glb_en),
    .comb_and_i (comb_and),
    .hit_i      (hit),
    .active_i   (active),
    .trig_o     (trig_o),
    .ch_trig_o  (ch_trig_o)
  );
endmodule

// File: rtl/lvl_trig_chk.sv
module lvl_trig_chk #(
  parameter int NUM_CH = 4,
  parameter int LVL_W  = 6
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    samp_vld_i,
  input logic                    glb_en,
  input logic                    comb_and,
  input logic [NUM_CH*3-1:0]     mode_flat,
  input logic [NUM_CH*LVL_W-1:0] upper_flat,
  input logic [NUM_CH*LVL_W-1:0] lower_flat,
  input logic                    trig_o,
  input logic [NUM_CH-1:0]       ch_trig_o
);
  localparam logic [LVL_W-1:0] LVL_MIN = {1'b1, {(LVL_W-1){1'b0}}};

  AST_QUIET_NO_SAMPLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !samp_vld_i |=> (!trig_o && ch_trig_o == '0)); // R5

  AST_GLOBAL_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !glb_en |=> (!trig_o && ch_trig_o == '0)); // R11

  AST_MERGE_NEEDS_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o |-> (|ch_trig_o)); // R10

  AST_OR_PASSES_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|ch_trig_o) && !$past(comb_and)) |-> trig_o); // R10

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    AST_OFF_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_flat[c*3 +: 3] == 3'd0) |=> !ch_trig_o[c]); // R9

    AST_NO_MIN_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (upper_flat[c*LVL_W +: LVL_W] != LVL_MIN) &&
      (lower_flat[c*LVL_W +: LVL_W] != LVL_MIN)); // R3
  end
endmodule

bind lvl_trig_top lvl_trig_chk #(.NUM_CH(NUM_CH), .LVL_W(LVL_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .samp_vld_i (samp_vld_i),
  .glb_en     (glb_en),
  .comb_and   (comb_and),
  .mode_flat  (mode_flat),
  .upper_flat (upper_flat),
  .lower_flat (lower_flat),
  .trig_o     (trig_o),
  .ch_trig_o  (ch_trig_o)
);

// File: tb/sim_lvl_trig_top.sv
`timescale 1ns/1ps
module sim_lvl_trig_top;
  localparam int NV = 10;
  // rise on ch0 at level 12: top bits, low bits, expected trigger
  localparam int        VS [NV] = '{20, 0, 10, 12, 13, 11, 12, -5, 31, -31};
  localparam logic [5:0] VL [NV] = '{63, 63, 63, 0, 63, 63, 0, 5, 0, 63};
  localparam bit        VT [NV] = '{0, 0, 0, 1, 0, 0, 1, 0, 1, 0};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [7:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        vld = 1'b0;
  logic [47:0] samp = '0;
  logic        trig;
  logic [3:0]  ch_trig;
  int          checks = 0;
  int          errors = 0;

  always #4 clk = ~clk;

  lvl_trig_top u0 (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .samp_vld_i(vld),
    .samp_i(samp), .trig_o(trig), .ch_trig_o(ch_trig)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input string req, input logic [7:0] a, input logic [7:0] exp);
    @(negedge clk);
    addr = a;
    #1;
    chk(req, 32'(rdata), 32'(exp));
  endtask

  task automatic step(input int s0, input int s1, input int s2, input int s3,
                      input logic [5:0] low);
    @(negedge clk);
    samp = {6'(s3), low, 6'(s2), low, 6'(s1), low, 6'(s0), low};
    vld = 1'b1;
    @(negedge clk);
    vld = 1'b0;
  endtask

  initial begin
    #(8 * 100000);
    errors++;
    $display("FAIL watchdog act=running exp=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 trig", 32'(trig), 0);
    chk("R1 ch_trig", 32'(ch_trig), 0);
    rd("R1 upper0", 8'h20, 8'h00);
    rd("R1 lower3", 8'h2B, 8'h00);
    rd("R1 mode0", 8'h10, 8'h00);
    // R2 level count, read-only
    rd("R2 count", 8'h02, 8'h3F);
    wr(8'h02, 8'h11);
    rd("R2 count after write", 8'h02, 8'h3F);

    // R12 map, R5 rise table
    wr(8'h00, 8'h01);
    wr(8'h10, 8'h01);
    wr(8'h20, 8'd12);
    rd("R12 upper0", 8'h20, 8'd12);
    rd("R12 mode0", 8'h10, 8'h01);
    for (int i = 0; i < NV; i++) begin
      step(VS[i], 0, 0, 0, VL[i]);
      chk($sformatf("R5 R4 R1 vec%0d trig", i), 32'(trig), 32'(VT[i]));
      chk($sformatf("R5 vec%0d ch0", i), 32'(ch_trig), 32'(VT[i]));
    end
    @(negedge clk);
    chk("R5 pulse one cycle", 32'(trig), 0);

    // R3 clamp
    wr(8'h21, 8'hE0);
    rd("R3 clamp readback", 8'h21, 8'hE1);
    wr(8'h29, 8'h20);
    rd("R3 clamp lower", 8'h29, 8'hE1);

    // R6 fall on ch1 at 0, ch0 off gets a rise (R9)
    wr(8'h10, 8'h00);
    wr(8'h11, 8'h02);
    wr(8'h21, 8'h00);
    step(0, 5, 0, 0, 6'h00);
    chk("R6 no fall yet", 32'(trig), 0);
    step(20, -1, 0, 0, 6'h00);
    chk("R6 fall trig", 32'(trig), 1);
    chk("R6 R9 fall ch only", 32'(ch_trig), 32'h2);

    // R7 window enter on ch2, inclusive bound
    wr(8'h11, 8'h00);
    wr(8'h12, 8'h03);
    wr(8'h22, 8'h04);
    wr(8'h2A, 8'hFC);
    step(0, 0, 10, 0, 6'h00);
    chk("R7 leaving no enter", 32'(trig), 0);
    step(0, 0, 4, 0, 6'h00);
    chk("R7 enter at upper bound", 32'(ch_trig), 32'h4);

    // R8 window exit on ch3
    wr(8'h12, 8'h00);
    wr(8'h13, 8'h04);
    wr(8'h23, 8'h04);
    wr(8'h2B, 8'hFC);
    step(0, 0, 0, -4, 6'h00);
    chk("R8 lower bound inside", 32'(trig), 0);
    step(0, 0, 0, -5, 6'h00);
    chk("R8 exit", 32'(ch_trig), 32'h8);

    // R9 unused code acts as off
    wr(8'h13, 8'h07);
    step(0, 0, 0, 0, 6'h00);
    step(0, 0, 0, -5, 6'h00);
    chk("R9 code 7 quiet", 32'(ch_trig), 0);
    chk("R9 code 7 trig", 32'(trig), 0);

    // R10 AND combine
    wr(8'h13, 8'h00);
    wr(8'h10, 8'h01);
    wr(8'h11, 8'h01);
    wr(8'h21, 8'd12);
    wr(8'h01, 8'h01);
    step(0, 0, 0, 0, 6'h00);
    step(20, 20, 0, 0, 6'h00);
    chk("R10 and both", 32'(trig), 1);
    step(0, 0, 0, 0, 6'h00);
    step(20, 0, 0, 0, 6'h00);
    chk("R10 and one", 32'(trig), 0);
    chk("R10 and ch", 32'(ch_trig), 32'h1);
    wr(8'h01, 8'h00);
    step(0, 0, 0, 0, 6'h00);
    step(20, 0, 0, 0, 6'h00);
    chk("R10 or one", 32'(trig), 1);

    // R11 global disable
    wr(8'h00, 8'h00);
    step(0, 0, 0, 0, 6'h00);
    step(20, 20, 0, 0, 6'h00);
    chk("R11 disabled trig", 32'(trig), 0);
    chk("R11 disabled ch", 32'(ch_trig), 0);

    // R1 first sample after a fresh reset
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    rd("R1 upper0 after reset", 8'h20, 8'h00);
    wr(8'h00, 8'h01);
    wr(8'h10, 8'h01);
    step(20, 0, 0, 0, 6'h00);
    chk("R1 first sample no edge", 32'(trig), 0);
    step(-3, 0, 0, 0, 6'h00);
    step(5, 0, 0, 0, 6'h00);
    chk("R1 later edge", 32'(trig), 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule